// File: doc/BRIEF.md
# Dual Limit-Compare Timer

This block holds two identical 32-bit timers. Each one steps up by one on every core clock edge and is compared against its own limit value. When the count equals the limit on a counting edge, the count returns to zero and the timer keeps running without any help from software. Each timer can also raise an interrupt at that point. The interrupt is latched once and stays high until software writes the timer's control register. That write clears it and arms it again, so software gets a periodic tick by writing control once after every event.

Software reaches both timers through one flat register port: an address, a write strobe with write data, and a read data bus that follows the address with no clock delay. Each timer has three words: count, control and limit. In the control register, bit 0 enables the interrupt. Bit 1 makes the timer stop counting while the core reports that it is halted. Bit 2 is a read-only copy of the pending interrupt. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `dual_limit_timer`

## Requirements
- R1: After reset, every register of both timers reads zero and both interrupt outputs are low.
- R2: Timer 0 count, control and limit sit at addresses 0x021, 0x022 and 0x023, and timer 1 uses 0x100, 0x101 and 0x102. Count and limit read back the last value written. Control reads back bits 1:0 as written and shows the pending flag in bit 2. Any other address reads zero.
- R3: On a counting edge where the count differs from the limit, the count rises by exactly one.
- R4: On a counting edge where the count equals the limit, the count becomes zero on that edge. A count above the limit keeps rising, rolls over from all ones to zero and then continues.
- R5: With the limit at all ones, the count runs freely and passes from all ones to zero.
- R6: While control bit 1 is set and `cpu_halted` is high, the count holds its value. With bit 1 clear, `cpu_halted` has no effect on counting.
- R7: When control bit 0 is set, a counting edge with count equal to limit sets the pending flag, and the timer's interrupt output is high from the next cycle. With bit 0 clear, no such edge changes the flag.
- R8: A set pending flag stays high until the control register is written. Any control write clears it, which re-arms the interrupt for the next limit event.
- R9: A write to the count register overrides the increment and the wrap on that edge, and it suppresses the limit event of that edge.
- R10: If a control write lands on the same edge as a limit event, the event is judged with the newly written enable, and the pending flag ends up set when that enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cpu_halted | input | 1 | High while the core is halted |
| reg_addr | input | 12 | Register address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register, zero if unmapped |
| tmr_irq | output | 2 | Pending interrupt per timer, bit n for timer n |

## Verification
Two pairs of events can fall on the same clock edge. A software write can coincide with the timer reaching its limit: a count write on that edge, or a control write on that edge. The bench loads a count two below the limit and then waits a known number of edges, so that the next write lands exactly on the matching edge. For a count write, it then checks that the written value is present and that no interrupt appeared. For a control write, it checks that the interrupt is set both when the write turns the enable on and when the write re-arms an interrupt that is already pending.

// File: rtl/lim_tmr_pkg.sv
`timescale 1ns/1ps
package lim_tmr_pkg;

  // control register field positions
  localparam int unsigned CTRL_IE_BIT   = 0;
  localparam int unsigned CTRL_GATE_BIT = 1;

  typedef struct packed {
    logic gate;  // hold count while core halted
    logic ie;    // interrupt on limit event
  } tmr_ctrl_t;

  // per-timer write strobes from the decoder
  typedef struct packed {
    logic cnt;
    logic ctrl;
    logic lim;
  } tmr_wstb_t;

endpackage

// File: rtl/lim_tmr_rst_sync.sv
`timescale 1ns/1ps
module lim_tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lim_tmr_decode.sv
`timescale 1ns/1ps
module lim_tmr_decode
  import lim_tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_TMR  = 2,
  parameter logic [N_TMR-1:0][ADDR_W-1:0] BASES = '0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              we,
  input  logic [N_TMR-1:0][CNT_W-1:0]       cnt_rd,
  input  logic [N_TMR-1:0][CNT_W-1:0]       ctrl_rd,
  input  logic [N_TMR-1:0][CNT_W-1:0]       lim_rd,
  output tmr_wstb_t [N_TMR-1:0]             wstb,
  output logic [CNT_W-1:0]                  rdata
);

  localparam int unsigned N_SEL = 3 * N_TMR;

  logic [N_SEL-1:0] sel_all;

  for (genvar t = 0; t < N_TMR; t++) begin : g_sel
    localparam logic [ADDR_W-1:0] A_CNT  = BASES[t];
    localparam logic [ADDR_W-1:0] A_CTRL = BASES[t] + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_LIM  = BASES[t] + ADDR_W'(2);

    assign sel_all[3*t]   = (addr == A_CNT);
    assign sel_all[3*t+1] = (addr == A_CTRL);
    assign sel_all[3*t+2] = (addr == A_LIM);

    assign wstb[t].cnt  = we && sel_all[3*t];
    assign wstb[t].ctrl = we && sel_all[3*t+1];
    assign wstb[t].lim  = we && sel_all[3*t+2];
  end

  always_comb begin
    rdata = '0;
    for (int t = 0; t < N_TMR; t++) begin
      if (sel_all[3*t])   rdata = rdata | cnt_rd[t];
      if (sel_all[3*t+1]) rdata = rdata | ctrl_rd[t];
      if (sel_all[3*t+2]) rdata = rdata | lim_rd[t];
    end
  end

  // R2
  addr_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_all));

endmodule

// File: rtl/lim_tmr_core.sv
`timescale 1ns/1ps
module lim_tmr_core
  import lim_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_halted,
  input  tmr_wstb_t        wstb,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_rd,
  output logic [CNT_W-1:0] ctrl_rd,
  output logic [CNT_W-1:0] lim_rd,
  output logic             irq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q, count_d, limit_q;
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic             pend_q, pend_d;
  logic             advance, at_limit, hit, ie_eff, count_en;

  // next-state logic
  always_comb begin
    advance  = !(ctrl_q.gate && cpu_halted);
    at_limit = (count_q == limit_q);
    hit      = advance && at_limit && !wstb.cnt;
    count_en = wstb.cnt || advance;

    if (wstb.cnt)     count_d = wdata;
    else if (at_limit) count_d = '0;
    else              count_d = count_q + ONE;

    ctrl_d.ie   = wdata[CTRL_IE_BIT];
    ctrl_d.gate = wdata[CTRL_GATE_BIT];

    ie_eff = wstb.ctrl ? ctrl_d.ie : ctrl_q.ie;
    if (hit && ie_eff) pend_d = 1'b1;
    else if (wstb.ctrl) pend_d = 1'b0;
    else               pend_d = pend_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      limit_q <= '0;
      ctrl_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (count_en)  count_q <= count_d;
      if (wstb.lim)  limit_q <= wdata;
      if (wstb.ctrl) ctrl_q  <= ctrl_d;
      pend_q <= pend_d;
    end
  end

  assign cnt_rd  = count_q;
  assign lim_rd  = limit_q;
  assign ctrl_rd = CNT_W'({pend_q, ctrl_q.gate, ctrl_q.ie});
  assign irq     = pend_q;

  // R3
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !at_limit && !wstb.cnt) |=> (count_q == $past(count_q) + ONE));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && at_limit && !wstb.cnt) |=> (count_q == '0));

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.gate && cpu_halted && !wstb.cnt) |=> $stable(count_q));

  // R9
  cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.cnt |=> (count_q == $past(wdata)));

  // R8
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wstb.ctrl) |=> pend_q);

  // R7
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ctrl_q.ie);

  // R10
  ctrl_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wstb.ctrl && wdata[CTRL_IE_BIT] && advance && at_limit && !wstb.cnt) |=> pend_q);

endmodule

// File: rtl/dual_limit_timer.sv
`timescale 1ns/1ps
module dual_limit_timer
  import lim_tmr_pkg::*;
#(
  parameter int unsigned      CNT_W   = 32,
  parameter int unsigned      ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] T0_BASE = 12'h021,
  parameter logic [ADDR_W-1:0] T1_BASE = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_halted,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [1:0]        tmr_irq
);

  localparam int unsigned N_TMR = 2;
  localparam logic [N_TMR-1:0][ADDR_W-1:0] BASES = {T1_BASE, T0_BASE};

  logic                         rst_int_n;
  tmr_wstb_t [N_TMR-1:0]        wstb;
  logic [N_TMR-1:0][CNT_W-1:0]  cnt_rd, ctrl_rd, lim_rd;

  lim_tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lim_tmr_decode #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .N_TMR  (N_TMR),
    .BASES  (BASES)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .addr    (reg_addr),
    .we      (reg_we),
    .cnt_rd  (cnt_rd),
    .ctrl_rd (ctrl_rd),
    .lim_rd  (lim_rd),
    .wstb    (wstb),
    .rdata   (reg_rdata)
  );

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    lim_tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .cpu_halted (cpu_halted),
      .wstb       (wstb[t]),
      .wdata      (reg_wdata),
      .cnt_rd     (cnt_rd[t]),
      .ctrl_rd    (ctrl_rd[t]),
      .lim_rd     (lim_rd[t]),
      .irq        (tmr_irq[t])
    );
  end

endmodule

// File: tb/test_dual_limit_timer.sv
`timescale 1ns/1ps
module test_dual_limit_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_halted;
  logic [11:0] reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  tmr_irq;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dual_limit_timer i_dual_limit_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_halted (cpu_halted),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .tmr_irq    (tmr_irq)
  );

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;  // write value, or expected read value
  } vec_t;

  localparam int N_VEC = 17;
  // run with cpu_halted high: once bit 1 is set, counts stay frozen
  localparam vec_t VEC [0:N_VEC-1] = '{
    '{1'b1, 12'h022, 32'h0000_0002},
    '{1'b1, 12'h101, 32'h0000_0002},
    '{1'b1, 12'h021, 32'h0000_1234},
    '{1'b0, 12'h021, 32'h0000_1234},
    '{1'b1, 12'h023, 32'h0000_ABCD},
    '{1'b0, 12'h023, 32'h0000_ABCD},
    '{1'b0, 12'h022, 32'h0000_0002},
    '{1'b1, 12'h100, 32'hDEAD_BEEF},
    '{1'b0, 12'h100, 32'hDEAD_BEEF},
    '{1'b1, 12'h102, 32'h0000_0005},
    '{1'b0, 12'h102, 32'h0000_0005},
    '{1'b0, 12'h101, 32'h0000_0002},
    '{1'b0, 12'h021, 32'h0000_1234},
    '{1'b0, 12'h024, 32'h0000_0000},
    '{1'b0, 12'h020, 32'h0000_0000},
    '{1'b0, 12'h103, 32'h0000_0000},
    '{1'b0, 12'h000, 32'h0000_0000}
  };

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic to_neg();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(posedge clk);
    #1;
    reg_we   = 1'b0;
    reg_addr = 12'h000;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check32(tag, reg_rdata, exp);
  endtask

  task automatic irq_chk(input int idx, input logic exp, input string tag);
    check32(tag, {31'b0, tmr_irq[idx]}, {31'b0, exp});
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_halted = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    cyc(3);
    @(negedge clk); rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    rd(12'h021, 32'h0, "R1 t0 count");
    rd(12'h022, 32'h0, "R1 t0 ctrl");
    rd(12'h023, 32'h0, "R1 t0 limit");
    rd(12'h100, 32'h0, "R1 t1 count");
    rd(12'h101, 32'h0, "R1 t1 ctrl");
    rd(12'h102, 32'h0, "R1 t1 limit");
    irq_chk(0, 1'b0, "R1 irq0");
    irq_chk(1, 1'b0, "R1 irq1");

    // R2 R6 vector table, core halted
    cpu_halted = 1'b1;
    for (int i = 0; i < N_VEC; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
      else           rd(VEC[i].addr, VEC[i].data, "R2 R6 table");
    end
    @(negedge clk); cpu_halted = 1'b0;

    // R3 increment
    wr(12'h022, 32'h0);
    wr(12'h023, 32'd100);
    wr(12'h021, 32'd10);
    rd(12'h021, 32'd10, "R3 count");
    rd(12'h021, 32'd11, "R3 count+1");
    cyc(3);
    rd(12'h021, 32'd14, "R3 count+4");

    // R4 wrap at limit
    wr(12'h023, 32'd12);
    wr(12'h021, 32'd10);
    rd(12'h021, 32'd10, "R4 a");
    rd(12'h021, 32'd11, "R4 b");
    rd(12'h021, 32'd12, "R4 at limit");
    rd(12'h021, 32'd0,  "R4 wrapped");
    irq_chk(0, 1'b0, "R7 ie off no irq");
    rd(12'h021, 32'd1,  "R4 after wrap");

    // R4 above limit rolls over
    wr(12'h023, 32'd5);
    wr(12'h021, 32'hFFFF_FFFF);
    rd(12'h021, 32'hFFFF_FFFF, "R4 above limit");
    rd(12'h021, 32'd0, "R4 rollover");
    rd(12'h021, 32'd1, "R4 rollover+1");

    // R7 interrupt on limit
    wr(12'h023, 32'd20);
    wr(12'h022, 32'h1);
    wr(12'h021, 32'd17);
    rd(12'h021, 32'd17, "R7 c17");
    irq_chk(0, 1'b0, "R7 irq before");
    rd(12'h021, 32'd18, "R7 c18");
    rd(12'h021, 32'd19, "R7 c19");
    rd(12'h021, 32'd20, "R7 c20");
    irq_chk(0, 1'b0, "R7 irq at limit");
    rd(12'h021, 32'd0, "R7 c0");
    irq_chk(0, 1'b1, "R7 irq raised");

    // R8 held, then re-arm, then periodic
    cyc(5);
    to_neg();
    irq_chk(0, 1'b1, "R8 irq held");
    rd(12'h022, 32'h5, "R8 ctrl shows pending");
    wr(12'h022, 32'h1);
    to_neg();
    irq_chk(0, 1'b0, "R8 re-arm clears");
    cyc(30);
    to_neg();
    irq_chk(0, 1'b1, "R8 periodic again");

    // R9 count write on the limit edge
    wr(12'h023, 32'd40);
    wr(12'h021, 32'd38);
    wr(12'h022, 32'h1);
    cyc(1);
    wr(12'h021, 32'd7);
    rd(12'h021, 32'd7, "R9 write wins");
    irq_chk(0, 1'b0, "R9 event suppressed");
    rd(12'h021, 32'd8, "R9 counts on");

    // R10 control write enabling on the limit edge
    wr(12'h022, 32'h0);
    wr(12'h023, 32'd60);
    wr(12'h021, 32'd58);
    cyc(2);
    wr(12'h022, 32'h1);
    rd(12'h021, 32'd0, "R10 wrapped");
    irq_chk(0, 1'b1, "R10 new enable sets");
    // R10 re-arm write on the limit edge keeps it set
    wr(12'h021, 32'd58);
    cyc(2);
    wr(12'h022, 32'h1);
    rd(12'h021, 32'd0, "R10 wrapped again");
    irq_chk(0, 1'b1, "R10 re-arm on edge");

    // R6 halt gating on timer 1
    wr(12'h101, 32'h2);
    wr(12'h102, 32'd1000);
    wr(12'h100, 32'd50);
    rd(12'h100, 32'd50, "R6 start");
    cpu_halted = 1'b1;
    rd(12'h100, 32'd50, "R6 held a");
    rd(12'h100, 32'd50, "R6 held b");
    cpu_halted = 1'b0;
    rd(12'h100, 32'd51, "R6 resumed");
    wr(12'h101, 32'h0);
    cpu_halted = 1'b1;
    wr(12'h100, 32'd200);
    rd(12'h100, 32'd200, "R6 gate off");
    rd(12'h100, 32'd201, "R6 halt ignored");
    cpu_halted = 1'b0;

    // R5 free running
    wr(12'h102, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFE);
    rd(12'h100, 32'hFFFF_FFFE, "R5 fe");
    rd(12'h100, 32'hFFFF_FFFF, "R5 ff");
    rd(12'h100, 32'h0, "R5 zero");
    rd(12'h100, 32'h1, "R5 one");
    irq_chk(1, 1'b0, "R7 t1 ie off");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule